// File: doc/BRIEF.md
# SMBus Slave with Fixed-Length Block Read and CRC-8 Packet Check

This block is the two-wire serial front end of a small register and nonvolatile store. It oversamples SCL and SDA with the system clock and finds the start and stop conditions. It decodes its own 7-bit address, a command byte and the transfer direction. It answers on an open-drain SDA pull-down and can hold SCL low with a second pull-down. The store sits behind a plain synchronous port: a write strobe, or a read strobe whose data arrive on the next clock, plus a busy input that the store raises while a slow byte write is under way.

Four transaction kinds are served. A command byte on its own loads the read pointer. A command followed by one or more data bytes stores them from that address upward and also loads the pointer. A read-direction address with no preceding block command returns the byte at the pointer. The block command 0xFD, then a repeated start and a read-direction address, returns a fixed count byte, then that many bytes from consecutive addresses, then an optional CRC-8 check byte.

Top module: `smbus_blk_slave`

## Requirements
- R1: An address byte whose upper seven bits differ from DEV_ADDR receives no ACK, and SDA stays released for every later bit until the next start or stop.
- R2: A command byte followed by a stop loads the read pointer with that byte. A read-direction address without a pending block command returns the byte stored at the pointer and leaves the pointer unchanged.
- R3: In a write transaction, the data bytes that follow the command byte C are stored at addresses C, C+1, and so on, each one ACKed. The read pointer is also loaded with C. A memory read strobe and a memory write strobe are never active together.
- R4: After a write-direction address, the command 0xFD, a repeated start and a read-direction address, the first byte the slave returns is BLOCK_LEN (0x20 by default).
- R5: The count byte is followed by BLOCK_LEN bytes read from the pointer onward, one address higher each time, wrapping modulo 2^AW. Afterwards the pointer has advanced by BLOCK_LEN.
- R6: With pec_en_i high, one more byte follows the last data byte. It is the CRC-8 (generator x^8+x^2+x+1, value 0x07, MSB first, initial value 0x00) over every byte of the transaction in bus order: write address byte with R/W=0, command, read address byte with R/W=1, count, data. The CRC restarts only at a start that follows a stop or reset.
- R7: With pec_en_i low, SDA is released after the last data byte, so any further byte the master clocks in reads as 0xFF.
- R8: After a stored data byte, SCL is held low until mem_busy_i falls, and no memory write or read strobe is issued while mem_busy_i is high.
- R9: A stop inside a byte returns the slave to idle, and the partial byte is not stored. A start inside a byte restarts address decoding.
- R10: The slave changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| scl_pull_o | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_pull_o | output | 1 | 1 pulls SDA low (ACK or a 0 data bit) |
| pec_en_i | input | 1 | 1 appends the CRC-8 byte to a block read |
| mem_addr_o | output | AW | Store address for read or write |
| mem_re_o | output | 1 | Read strobe; data expected on the next clock |
| mem_we_o | output | 1 | Write strobe for mem_wdata_o |
| mem_wdata_o | output | 8 | Byte to store |
| mem_rdata_i | input | 8 | Byte read, valid the clock after mem_re_o |
| mem_busy_i | input | 1 | Store is finishing a write |

## Verification
The bench builds the slave with DEV_ADDR 0x34, AW 8 and BLOCK_LEN 32, so the whole 256-byte address space is visible. A block started at 0xF0 shows the pointer wrapping past 0xFF and ending at 0x10. Its store model stays busy for 400 clocks per byte against a bus bit time of about 20 clocks, so the SCL hold is long enough to measure at the bus. The PEC value is recomputed bit-serially from the bytes the bench itself sent and received.

// File: rtl/smbus_blk_pkg.sv
package smbus_blk_pkg;

  localparam logic [7:0] CMD_BLOCK = 8'hFD;
  localparam logic [7:0] CRC_POLY  = 8'h07;

  typedef enum logic [3:0] {
    ST_IDLE, ST_RX, ST_RX_ACK, ST_WAIT, ST_FETCH,
    ST_LOAD, ST_TX, ST_TX_ACK, ST_IGNORE
  } sl_state_e;

  typedef enum logic [1:0] {RK_ADDR, RK_CMD, RK_DATA} rx_kind_e;
  typedef enum logic [1:0] {TK_RECV, TK_COUNT, TK_DATA, TK_PEC} tx_kind_e;

  // byte-wide CRC-8 step, shift-left form
  function automatic logic [7:0] crc8_step(input logic [7:0] c, input logic [7:0] b);
    logic [7:0] r;
    r = c ^ b;
    for (int k = 0; k < 8; k++) begin
      r = r[7] ? ((r << 1) ^ CRC_POLY) : (r << 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/smbus_line_sampler.sv
module smbus_line_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [1:0] scl_sync, sda_sync;
  logic       scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sync <= 2'b11;
      sda_sync <= 2'b11;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[0], scl_i};
      sda_sync <= {sda_sync[0], sda_i};
      scl_d    <= scl_sync[1];
      sda_d    <= sda_sync[1];
    end
  end

  assign scl_s    = scl_sync[1];
  assign sda_s    = sda_sync[1];
  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  assign start_ev = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_ev  = scl_s & scl_d & ~sda_d & sda_s;

  assert_one_event_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_ev, stop_ev, scl_rise, scl_fall}));

endmodule

// File: rtl/smbus_crc_acc.sv
module smbus_crc_acc import smbus_blk_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       upd,
  input  logic [7:0] din,
  output logic [7:0] crc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   crc <= 8'h00;
    else if (clr) crc <= 8'h00;
    else if (upd) crc <= crc8_step(crc, din);
  end

  assert_crc_init_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (crc == 8'h00));

endmodule

// File: rtl/smbus_blk_slave.sv
module smbus_blk_slave import smbus_blk_pkg::*; #(
  parameter logic [6:0] DEV_ADDR  = 7'h34,
  parameter int         AW        = 8,
  parameter int         BLOCK_LEN = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          scl_pull_o,
  output logic          sda_pull_o,
  input  logic          pec_en_i,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_re_o,
  output logic          mem_we_o,
  output logic [7:0]    mem_wdata_o,
  input  logic [7:0]    mem_rdata_i,
  input  logic          mem_busy_i
);
  localparam int            IW       = (BLOCK_LEN > 1) ? $clog2(BLOCK_LEN) : 1;
  localparam logic [IW-1:0] LAST_IDX = IW'(BLOCK_LEN - 1);
  localparam logic [7:0]    COUNT_B  = 8'(BLOCK_LEN);

  logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;

  smbus_line_sampler u_sampler (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  sl_state_e     state;
  rx_kind_e      rx_kind;
  tx_kind_e      tx_kind;
  logic [3:0]    bit_cnt;
  logic [7:0]    shreg, txbyte;
  logic          is_read, ack_q, blk_armed, in_txn, sda_oe_q;
  logic [AW-1:0] ptr, wr_addr;
  logic [IW-1:0] blk_idx;

  // named internal events
  logic       byte_done, addr_hit, crc_clr, crc_upd, load_data;
  logic [7:0] crc_in, crc_val, tx_next;
  logic [2:0] nidx;

  assign byte_done = (state == ST_RX) && scl_fall && (bit_cnt == 4'd8);
  assign addr_hit  = (shreg[7:1] == DEV_ADDR);
  assign load_data = (state == ST_LOAD) && (tx_kind == TK_DATA);
  assign nidx      = bit_cnt[2:0] - 3'd1;

  always_comb begin
    case (tx_kind)
      TK_COUNT: tx_next = COUNT_B;
      TK_PEC:   tx_next = crc_val;
      default:  tx_next = mem_rdata_i;
    endcase
  end

  assign crc_clr = start_ev && !in_txn;
  assign crc_upd = (byte_done && (rx_kind != RK_ADDR || addr_hit)) ||
                   ((state == ST_LOAD) && (tx_kind != TK_PEC));
  assign crc_in  = (state == ST_LOAD) ? tx_next : shreg;

  smbus_crc_acc u_crc (
    .clk(clk), .rst_n(rst_n), .clr(crc_clr), .upd(crc_upd),
    .din(crc_in), .crc(crc_val)
  );

  // memory port
  assign mem_we_o    = byte_done && (rx_kind == RK_DATA);
  assign mem_wdata_o = shreg;
  assign mem_re_o    = (state == ST_FETCH) && !mem_busy_i &&
                       (tx_kind == TK_RECV || tx_kind == TK_DATA);
  assign mem_addr_o  = (state == ST_FETCH) ? ptr : wr_addr;

  assign scl_pull_o  = ((state == ST_WAIT || state == ST_FETCH) && mem_busy_i) ||
                       (state == ST_FETCH) || (state == ST_LOAD);
  assign sda_pull_o  = sda_oe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; rx_kind <= RK_ADDR; tx_kind <= TK_RECV;
      bit_cnt <= '0; shreg <= '0; txbyte <= '0;
      is_read <= 1'b0; ack_q <= 1'b0; blk_armed <= 1'b0; in_txn <= 1'b0;
      sda_oe_q <= 1'b0; ptr <= '0; wr_addr <= '0; blk_idx <= '0;
    end else if (stop_ev) begin
      state <= ST_IDLE; sda_oe_q <= 1'b0; blk_armed <= 1'b0; in_txn <= 1'b0;
    end else if (start_ev) begin
      state <= ST_RX; rx_kind <= RK_ADDR; bit_cnt <= '0;
      sda_oe_q <= 1'b0; in_txn <= 1'b1;
    end else begin
      case (state)
        ST_RX: begin
          if (scl_rise && bit_cnt < 4'd8) begin
            shreg   <= {shreg[6:0], sda_s};
            bit_cnt <= bit_cnt + 4'd1;
          end
          if (byte_done) begin
            case (rx_kind)
              RK_ADDR: begin
                if (addr_hit) begin
                  sda_oe_q <= 1'b1;
                  state    <= ST_RX_ACK;
                  is_read  <= shreg[0];
                  if (shreg[0]) begin
                    tx_kind   <= blk_armed ? TK_COUNT : TK_RECV;
                    blk_armed <= 1'b0;
                    blk_idx   <= '0;
                  end else begin
                    rx_kind <= RK_CMD;
                  end
                end else begin
                  state <= ST_IGNORE;
                end
              end
              RK_CMD: begin
                sda_oe_q <= 1'b1;
                state    <= ST_RX_ACK;
                rx_kind  <= RK_DATA;
                if (shreg == CMD_BLOCK) blk_armed <= 1'b1;
                else begin
                  ptr     <= AW'(shreg);
                  wr_addr <= AW'(shreg);
                end
              end
              default: begin
                sda_oe_q <= 1'b1;
                state    <= ST_RX_ACK;
                wr_addr  <= wr_addr + 1'b1;
              end
            endcase
          end
        end
        ST_RX_ACK: if (scl_fall) begin
          sda_oe_q <= 1'b0;
          bit_cnt  <= '0;
          state    <= is_read ? ST_FETCH : ST_WAIT;
        end
        ST_WAIT:  if (!mem_busy_i) state <= ST_RX;
        ST_FETCH: if (!mem_busy_i) state <= ST_LOAD;
        ST_LOAD: begin
          txbyte   <= tx_next;
          sda_oe_q <= !tx_next[7];
          bit_cnt  <= 4'd7;
          state    <= ST_TX;
          if (load_data) ptr <= ptr + 1'b1;
        end
        ST_TX: if (scl_fall) begin
          if (bit_cnt == 4'd0) begin
            sda_oe_q <= 1'b0;
            state    <= ST_TX_ACK;
          end else begin
            bit_cnt  <= bit_cnt - 4'd1;
            sda_oe_q <= !txbyte[nidx];
          end
        end
        ST_TX_ACK: begin
          if (scl_rise) ack_q <= !sda_s;
          if (scl_fall) begin
            if (!ack_q) state <= ST_IGNORE;
            else begin
              case (tx_kind)
                TK_RECV:  state <= ST_FETCH;
                TK_COUNT: begin tx_kind <= TK_DATA; blk_idx <= '0; state <= ST_FETCH; end
                TK_DATA: begin
                  if (blk_idx == LAST_IDX) begin
                    if (pec_en_i) begin tx_kind <= TK_PEC; state <= ST_FETCH; end
                    else state <= ST_IGNORE;
                  end else begin
                    blk_idx <= blk_idx + 1'b1;
                    state   <= ST_FETCH;
                  end
                end
                default: state <= ST_IGNORE;
              endcase
            end
          end
        end
        default: ;
      endcase
    end
  end

  assert_ignore_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IGNORE) |-> !sda_pull_o);
  assert_foreign_nack_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && rx_kind == RK_ADDR && !addr_hit) |=> !sda_pull_o);
  assert_rw_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we_o && mem_re_o));
  assert_ptr_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    load_data |=> (ptr == $past(ptr) + 1'b1));
  assert_no_write_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we_o || mem_re_o) |-> !mem_busy_i);
  assert_hold_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_pull_o) |-> !mem_busy_i);
  assert_stop_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> (state == ST_IDLE));
  assert_sda_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_pull_o != $past(sda_pull_o)) |-> !$past(scl_s));

endmodule

// File: tb/smbus_blk_slave_tb.sv
module smbus_blk_slave_tb;
  localparam logic [6:0] DEV  = 7'h34;
  localparam int         AW   = 8;
  localparam int         BLEN = 32;
  localparam int         HALF = 10;
  localparam int         BUSY_CYC = 400;
  localparam logic [7:0] AW_B = {DEV, 1'b0};
  localparam logic [7:0] AR_B = {DEV, 1'b1};

  // {address, data} write-then-read vectors
  localparam logic [15:0] VEC [6] = '{16'h10A5, 16'h115A, 16'h7F00,
                                      16'hFFFF, 16'h0081, 16'hC33C};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic scl_m = 1'b1, sda_m = 1'b1, pec_en = 1'b0;
  logic scl_pull, sda_pull, scl_line, sda_line;
  logic [AW-1:0] mem_addr;
  logic mem_re, mem_we, mem_busy;
  logic [7:0] mem_wdata, mem_rdata;

  assign scl_line = scl_m & ~scl_pull;
  assign sda_line = sda_m & ~sda_pull;

  smbus_blk_slave #(.DEV_ADDR(DEV), .AW(AW), .BLOCK_LEN(BLEN)) u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
    .scl_pull_o(scl_pull), .sda_pull_o(sda_pull), .pec_en_i(pec_en),
    .mem_addr_o(mem_addr), .mem_re_o(mem_re), .mem_we_o(mem_we),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .mem_busy_i(mem_busy)
  );

  // store model
  logic [7:0] mem [256];
  int busy_cnt;
  assign mem_busy = (busy_cnt != 0);
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i * 37 + 5);
      busy_cnt  <= 0;
      mem_rdata <= 8'h00;
    end else begin
      if (mem_we) begin
        mem[mem_addr] <= mem_wdata;
        busy_cnt <= BUSY_CYC;
      end else if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
      if (mem_re) mem_rdata <= mem[mem_addr];
    end
  end

  int checks = 0, errors = 0, we_count = 0, busy_viol = 0, sda_viol = 0;
  int last_stretch = 0;
  bit done = 1'b0;
  logic [7:0] exp_mem [256];
  logic prev_pull = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_we) begin
        we_count++;
        if (mem_busy) busy_viol++;
      end
      if (sda_pull !== prev_pull && scl_line === 1'b1) sda_viol++;
    end
    prev_pull = sda_pull;
  end

  function automatic logic [7:0] ref_crc(input logic [7:0] c, input logic [7:0] b);
    logic fb;
    for (int i = 7; i >= 0; i--) begin
      fb = c[7] ^ b[i];
      c  = {c[6:0], 1'b0};
      if (fb) c = c ^ 8'h07;
    end
    return c;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic half();
    repeat (HALF) @(negedge clk);
  endtask

  task automatic release_scl();
    int n = 0;
    scl_m = 1'b1;
    @(negedge clk);
    while (scl_line !== 1'b1) begin n++; @(negedge clk); end
    last_stretch = n;
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; half(); release_scl(); half(); scl_m = 1'b0;
  endtask

  task automatic recv_bit(output logic b);
    sda_m = 1'b1; half(); release_scl();
    repeat (HALF / 2) @(negedge clk);
    b = sda_line;
    repeat (HALF / 2) @(negedge clk);
    scl_m = 1'b0;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; half(); release_scl(); half(); sda_m = 1'b0; half(); scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; half(); release_scl(); half(); sda_m = 1'b1; half();
  endtask

  task automatic wtx(input logic [7:0] b, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    recv_bit(a);
    ack = !a;
  endtask

  task automatic rtx(output logic [7:0] b, input logic ack);
    logic v;
    for (int i = 7; i >= 0; i--) begin recv_bit(v); b[i] = v; end
    send_bit(!ack);
  endtask

  task automatic set_ptr(input logic [7:0] a, input string req);
    logic k1, k2;
    bus_start(); wtx(AW_B, k1); wtx(a, k2); bus_stop();
    chk(req, {k1, k2}, 2'b11);
  endtask

  task automatic recv_one(output logic [7:0] d);
    logic k;
    bus_start(); wtx(AR_B, k); rtx(d, 1'b0); bus_stop();
    chk("R2 receive address ACK", k, 1'b1);
  endtask

  task automatic block_read(input logic [7:0] p0, input logic pec, input string req);
    logic k1, k2, k3;
    logic [7:0] d, crc;
    pec_en = pec;
    bus_start(); wtx(AW_B, k1); wtx(8'hFD, k2);
    bus_start(); wtx(AR_B, k3);
    chk("R4 block header ACKs", {k1, k2, k3}, 3'b111);
    crc = ref_crc(ref_crc(ref_crc(8'h00, AW_B), 8'hFD), AR_B);
    rtx(d, 1'b1);
    chk("R4 count byte", d, 8'(BLEN));
    crc = ref_crc(crc, d);
    for (int i = 0; i < BLEN; i++) begin
      rtx(d, 1'b1);
      chk(req, d, exp_mem[8'(p0 + i)]);
      crc = ref_crc(crc, d);
    end
    rtx(d, 1'b0);
    if (pec) chk("R6 PEC byte", d, crc);
    else     chk("R7 released after last byte", d, 8'hFF);
    bus_stop();
  endtask

  initial begin
    logic [7:0] d, a;
    logic k1, k2, k3;
    int wc;
    for (int i = 0; i < 256; i++) exp_mem[i] = 8'(i * 37 + 5);
    repeat (5) @(negedge clk);
    chk("R10 reset SDA released", sda_pull, 1'b0);
    chk("R8 reset SCL released", scl_pull, 1'b0);
    chk("R3 reset no strobes", {mem_we, mem_re}, 2'b00);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // table walk: write byte then read it back (R3, R2)
    for (int v = 0; v < 6; v++) begin
      a = VEC[v][15:8];
      d = VEC[v][7:0];
      bus_start(); wtx(AW_B, k1); wtx(a, k2); wtx(d, k3); bus_stop();
      chk("R3 write byte ACKs", {k1, k2, k3}, 3'b111);
      exp_mem[a] = d;
      recv_one(d);
      chk("R3 stored byte read back", d, exp_mem[a]);
    end

    // R2: pointer load and repeated receive
    set_ptr(8'h22, "R2 send byte ACKs");
    recv_one(d); chk("R2 receive at pointer", d, exp_mem[8'h22]);
    recv_one(d); chk("R2 pointer unchanged by receive", d, exp_mem[8'h22]);

    // R3: two data bytes, stored at C and C+1
    bus_start(); wtx(AW_B, k1); wtx(8'h30, k2); wtx(8'h11, k3); wtx(8'h22, k1); bus_stop();
    exp_mem[8'h30] = 8'h11; exp_mem[8'h31] = 8'h22;
    set_ptr(8'h31, "R2 send byte ACKs");
    recv_one(d); chk("R3 second data byte at C+1", d, 8'h22);

    // R8: stretch after a stored byte
    bus_start(); wtx(AW_B, k1); wtx(8'h55, k2); wtx(8'h99, k3);
    bus_stop();
    exp_mem[8'h55] = 8'h99;
    chk("R8 SCL held while store busy", (last_stretch >= BUSY_CYC / 2), 1'b1);
    recv_one(d); chk("R8 stretched write stored", d, 8'h99);

    // R4 R5 R6: block with PEC
    set_ptr(8'h40, "R2 send byte ACKs");
    block_read(8'h40, 1'b1, "R5 block data with PEC");
    recv_one(d); chk("R5 pointer advanced by block", d, exp_mem[8'h60]);

    // R5 R7: wrapping block without PEC
    set_ptr(8'hF0, "R2 send byte ACKs");
    block_read(8'hF0, 1'b0, "R5 wrapping block data");
    recv_one(d); chk("R5 pointer wrapped", d, exp_mem[8'h10]);

    // R1: foreign address
    wc = we_count;
    bus_start(); wtx({7'h50, 1'b0}, k1); wtx(8'h12, k2); wtx(8'h34, k3); bus_stop();
    chk("R1 foreign write not ACKed", {k1, k2, k3}, 3'b000);
    bus_start(); wtx({7'h50, 1'b1}, k1); rtx(d, 1'b0); bus_stop();
    chk("R1 foreign read address not ACKed", k1, 1'b0);
    chk("R1 foreign read sees released SDA", d, 8'hFF);
    chk("R1 nothing stored", we_count, wc);

    // R9: stop inside a data byte, then start inside a byte
    wc = we_count;
    bus_start(); wtx(AW_B, k1); wtx(8'h70, k2);
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    bus_stop();
    chk("R9 partial byte not stored", we_count, wc);
    recv_one(d); chk("R9 slave usable after stop abort", d, exp_mem[8'h70]);
    bus_start(); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    bus_start(); wtx(AR_B, k1); rtx(d, 1'b0); bus_stop();
    chk("R9 start inside byte restarts decode", {k1, d}, {1'b1, exp_mem[8'h70]});

    chk("R8 no store strobe while busy", busy_viol, 0);
    chk("R10 SDA drive changed only with SCL low", sda_viol, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R9 watchdog: actual hang expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule